// File: doc/BRIEF.md
# Bus-Stepped Wiper Position Counter

This block holds the 6-bit tap position of one digitally controlled potentiometer. It drives a registered, single-hot select over the 64 tap switches of the resistor string. Code 0 closes the switch at the low end of the string, and code 63 closes the switch at the high end. The surrounding command logic can give the position a new value in three ways: it can write a value received over the serial bus, it can copy a stored setting from a data register, or it can have the block recall data register 0 in the first cycle after reset.

For fine tuning, the command decoder pulses `step_arm_i` once it has acknowledged the increment/decrement command. From then on the block watches the raw serial clock and data lines by itself. Each clock high pulse moves the wiper by one tap. The direction comes from the level the data line had when the clock rose: high moves toward the high terminal, low toward the low terminal. The step is applied when the clock falls, so a stop condition placed inside the final high phase cancels that pulse and ends the session. A start condition also ends the session. Steps saturate at both ends of the range.

Top module: `wiper_ctr_top`

## Requirements
- R1: `tap_sel_o` always has exactly one bit set. Bit k is set one clock after `pos_o` equals k, so code 0 selects bit 0 (low terminal) and code 63 selects bit 63 (high terminal).
- R2: In the first clock after reset is released, `pos_o` takes the value of `dr0_i`.
- R3: When `wr_en_i` is high, `pos_o` equals `wr_val_i` in the following clock.
- R4: When `xfer_en_i` is high and `wr_en_i` is low, `pos_o` equals `xfer_val_i` in the following clock.
- R5: The load sources have a fixed priority: the power-up recall first, then the direct write, then the transfer, then a step. When a write and a transfer arrive together, the written value wins.
- R6: While no session is active (`stepping_o` low), serial clock pulses leave `pos_o` unchanged. A pulse on `step_arm_i` starts a session, and `stepping_o` is high from the next clock.
- R7: Within a session, a serial clock high pulse adds one to `pos_o` if the data line was high at the clock's rising edge, and subtracts one if it was low. The change appears only after the clock falls.
- R8: An increment at 63 leaves `pos_o` at 63, and a decrement at 0 leaves it at 0.
- R9: A stop condition (data rising while the clock is high) ends the session. The clock pulse that contains the stop moves nothing, and later pulses move nothing either.
- R10: A start condition (data falling while the clock is high) ends the session.
- R11: During reset, `pos_o` is 0, `tap_sel_o` selects bit 0 and `stepping_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Raw serial bus clock |
| sda_i | input | 1 | Raw serial bus data |
| step_arm_i | input | 1 | One-cycle pulse that opens a stepping session |
| wr_en_i | input | 1 | Direct write strobe |
| wr_val_i | input | 6 | Value written over the bus |
| xfer_en_i | input | 1 | Parallel transfer strobe |
| xfer_val_i | input | 6 | Data register contents for a transfer |
| dr0_i | input | 6 | Data register 0 contents, recalled after reset |
| pos_o | output | 6 | Current wiper position |
| tap_sel_o | output | 64 | Single-hot tap switch select |
| stepping_o | output | 1 | Stepping session active |

## Verification
The bench builds the block with its defaults: a 6-bit position, 64 taps and a two-stage synchronizer. These defaults put both saturation ends within a few steps of a direct write, and make the end-terminal tap bits 0 and 63 directly observable. The bench holds each bus phase for eight clocks, which is longer than the synchronizer plus edge-detect delay. This lets it sample the position while the clock is still high, so it can show that a step is deferred until the clock falls and is dropped when a stop condition arrives in that high phase.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  // Source chosen for the next wiper position, in priority order.
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_WRITE  = 3'd2,
    SRC_XFER   = 3'd3,
    SRC_UP     = 3'd4,
    SRC_DOWN   = 3'd5
  } pos_src_e;
endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
  parameter int STAGES    = 2,
  parameter int N         = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] chain_d;
    if (s == 0) begin : g_first
      always_comb chain_d = d_i;
    end else begin : g_rest
      always_comb chain_d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= {N{RESET_VAL}};
      else        chain_q[s] <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wpr_step_ctl.sv
module wpr_step_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic step_arm_i,
  output logic active_o,
  output logic step_up_o,
  output logic step_dn_o
);
  logic scl_q, sda_q;
  logic rise, fall, stop_det, start_det;
  logic active_q, active_d;
  logic pend_q, pend_d;
  logic dir_q, dir_d;
  logic up_q, up_d, dn_q, dn_d;

  // Edge and bus-condition detection on synchronized lines.
  always_comb begin
    rise      = scl_s_i & ~scl_q;
    fall      = ~scl_s_i & scl_q;
    stop_det  = scl_s_i & scl_q & sda_s_i & ~sda_q;
    start_det = scl_s_i & scl_q & ~sda_s_i & sda_q;
  end

  // Session control: the direction is captured at the rising edge and the
  // step is released at the falling edge unless a bus condition intervenes.
  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    dir_d    = dir_q;
    up_d     = 1'b0;
    dn_d     = 1'b0;
    if (step_arm_i) begin
      active_d = 1'b1;
      pend_d   = 1'b0;
    end else if (stop_det || start_det) begin
      active_d = 1'b0;
      pend_d   = 1'b0;
    end else if (active_q) begin
      if (rise) begin
        pend_d = 1'b1;
        dir_d  = sda_s_i;
      end else if (fall && pend_q) begin
        pend_d = 1'b0;
        up_d   = dir_q;
        dn_d   = ~dir_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      dir_q    <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
    end else begin
      scl_q    <= scl_s_i;
      sda_q    <= sda_s_i;
      active_q <= active_d;
      pend_q   <= pend_d;
      dir_q    <= dir_d;
      up_q     <= up_d;
      dn_q     <= dn_d;
    end
  end

  assign active_o  = active_q;
  assign step_up_o = up_q;
  assign step_dn_o = dn_q;

  // R6: a step is only issued from within a session
  a_r6_step_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_o || step_dn_o) |-> $past(active_q));
  // R7: never both directions at once
  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({step_up_o, step_dn_o}) <= 1);
  // R9: a stop closes the session
  a_r9_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !step_arm_i) |=> (!active_q && !step_up_o && !step_dn_o));
  // R10: a start closes the session
  a_r10_start_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !step_arm_i) |=> !active_q);
endmodule

// File: rtl/wpr_counter.sv
module wpr_counter
  import wpr_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         xfer_en_i,
  input  logic [W-1:0] xfer_val_i,
  input  logic [W-1:0] dr0_i,
  input  logic         step_up_i,
  input  logic         step_dn_i,
  output logic [W-1:0] pos_o
);
  localparam logic [W-1:0] POS_MAX = {W{1'b1}};
  localparam logic [W-1:0] POS_MIN = '0;

  logic     recall_q;
  logic     [W-1:0] pos_q, pos_d;
  pos_src_e src;

  // Source selection with fixed priority.
  always_comb begin
    if (recall_q)                            src = SRC_RECALL;
    else if (wr_en_i)                        src = SRC_WRITE;
    else if (xfer_en_i)                      src = SRC_XFER;
    else if (step_up_i && pos_q != POS_MAX)  src = SRC_UP;
    else if (step_dn_i && pos_q != POS_MIN)  src = SRC_DOWN;
    else                                     src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: pos_d = dr0_i;
      SRC_WRITE:  pos_d = wr_val_i;
      SRC_XFER:   pos_d = xfer_val_i;
      SRC_UP:     pos_d = pos_q + W'(1);
      SRC_DOWN:   pos_d = pos_q - W'(1);
      default:    pos_d = pos_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q <= 1'b1;
      pos_q    <= '0;
    end else begin
      recall_q <= 1'b0;
      pos_q    <= pos_d;
    end
  end

  assign pos_o = pos_q;

  // R2: recall loads data register 0
  a_r2_recall: assert property (@(posedge clk) disable iff (!rst_n)
    recall_q |=> (pos_q == $past(dr0_i)));
  // R3 / R5: write beats transfer and step
  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !recall_q) |=> (pos_q == $past(wr_val_i)));
  // R4: transfer when no write
  a_r4_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en_i && !wr_en_i && !recall_q) |=> (pos_q == $past(xfer_val_i)));
  // R7: single-step increment
  a_r7_inc_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_i && !wr_en_i && !xfer_en_i && !recall_q && pos_q != POS_MAX)
    |=> (pos_q == $past(pos_q) + W'(1)));
  // R8: saturation at both ends
  a_r8_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_i && !wr_en_i && !xfer_en_i && !recall_q && pos_q == POS_MAX)
    |=> (pos_q == POS_MAX));
  a_r8_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn_i && !wr_en_i && !xfer_en_i && !recall_q && pos_q == POS_MIN)
    |=> (pos_q == POS_MIN));
endmodule

// File: rtl/wpr_decode.sv
module wpr_decode #(
  parameter int W    = 6,
  parameter int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    pos_i,
  output logic [TAPS-1:0] tap_sel_o
);
  logic [TAPS-1:0] tap_d, tap_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_d[k] = (pos_i == W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= TAPS'(1);
    else        tap_q <= tap_d;
  end

  assign tap_sel_o = tap_q;

  // R1: exactly one switch closed
  a_r1_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel_o) == 1);
  // R1: selected switch follows the previous position
  a_r1_tap_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel_o == (TAPS'(1) << $past(pos_i)));
endmodule

// File: rtl/wiper_ctr_top.sv
module wiper_ctr_top #(
  parameter int W           = 6,
  parameter int SYNC_STAGES = 2,
  localparam int TAPS       = 1 << W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            step_arm_i,
  input  logic            wr_en_i,
  input  logic [W-1:0]    wr_val_i,
  input  logic            xfer_en_i,
  input  logic [W-1:0]    xfer_val_i,
  input  logic [W-1:0]    dr0_i,
  output logic [W-1:0]    pos_o,
  output logic [TAPS-1:0] tap_sel_o,
  output logic            stepping_o
);
  logic [1:0] bus_s;
  logic       step_up, step_dn;

  wpr_sync #(.STAGES(SYNC_STAGES), .N(2), .RESET_VAL(1'b1)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  wpr_step_ctl i_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s_i    (bus_s[1]),
    .sda_s_i    (bus_s[0]),
    .step_arm_i (step_arm_i),
    .active_o   (stepping_o),
    .step_up_o  (step_up),
    .step_dn_o  (step_dn)
  );

  wpr_counter #(.W(W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_val_i   (wr_val_i),
    .xfer_en_i  (xfer_en_i),
    .xfer_val_i (xfer_val_i),
    .dr0_i      (dr0_i),
    .step_up_i  (step_up),
    .step_dn_i  (step_dn),
    .pos_o      (pos_o)
  );

  wpr_decode #(.W(W), .TAPS(TAPS)) i_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos_i     (pos_o),
    .tap_sel_o (tap_sel_o)
  );
endmodule

// File: tb/test_wiper_ctr_top.sv
module test_wiper_ctr_top;
  localparam int W    = 6;
  localparam int TAPS = 1 << W;
  localparam int HOLD = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scl = 1'b1, sda = 1'b1, arm = 1'b0;
  logic            wr_en = 1'b0, xfer_en = 1'b0;
  logic [W-1:0]    wr_val = '0, xfer_val = '0, dr0 = 6'h15;
  logic [W-1:0]    pos;
  logic [TAPS-1:0] tap;
  logic            stepping;
  int              n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  wiper_ctr_top i_wiper_ctr_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .step_arm_i(arm),
    .wr_en_i(wr_en), .wr_val_i(wr_val), .xfer_en_i(xfer_en),
    .xfer_val_i(xfer_val), .dr0_i(dr0), .pos_o(pos), .tap_sel_o(tap),
    .stepping_o(stepping)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_pos(input logic [W-1:0] v);
    wr_val = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_arm;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic pulse(input logic d);
    scl = 1'b0; wait_clk(HOLD);
    sda = d;    wait_clk(HOLD);
    scl = 1'b1; wait_clk(HOLD);
    scl = 1'b0; wait_clk(HOLD);
  endtask

  task automatic t_reset;
    wait_clk(3);
    chk(pos == 0, "R11 pos in reset", pos, 0);
    chk(tap == TAPS'(1), "R11 tap in reset", tap, 1);
    chk(!stepping, "R11 session in reset", stepping, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pos == 6'h15, "R2 recall of dr0", pos, 6'h15);
    @(negedge clk);
    chk(tap == (TAPS'(1) << 6'h15), "R1 tap after recall", tap, TAPS'(1) << 6'h15);
  endtask

  task automatic t_direct;
    write_pos(6'h3F);
    chk(pos == 6'h3F, "R3 direct write", pos, 6'h3F);
    @(negedge clk);
    chk(tap == (TAPS'(1) << 63), "R1 high terminal bit 63", tap, TAPS'(1) << 63);
    write_pos(6'h00);
    chk(pos == 0, "R3 direct write zero", pos, 0);
    @(negedge clk);
    chk(tap == TAPS'(1), "R1 low terminal bit 0", tap, 1);
  endtask

  task automatic t_xfer;
    xfer_val = 6'h2A; xfer_en = 1'b1;
    @(negedge clk);
    xfer_en = 1'b0;
    chk(pos == 6'h2A, "R4 parallel transfer", pos, 6'h2A);
  endtask

  task automatic t_prio;
    wr_val = 6'h10; xfer_val = 6'h20; wr_en = 1'b1; xfer_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; xfer_en = 1'b0;
    chk(pos == 6'h10, "R5 write over transfer", pos, 6'h10);
  endtask

  task automatic t_idle;
    write_pos(6'h08);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    chk(pos == 6'h08, "R6 no steps outside session", pos, 6'h08);
    chk(!stepping, "R6 session idle", stepping, 0);
    scl = 1'b1; sda = 1'b1; wait_clk(HOLD);
  endtask

  task automatic t_steps;
    write_pos(6'h20);
    do_arm;
    chk(stepping, "R6 session opened", stepping, 1);
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    chk(pos == 6'h23, "R7 three increments", pos, 6'h23);
    pulse(1'b0); pulse(1'b0);
    chk(pos == 6'h21, "R7 two decrements", pos, 6'h21);
    scl = 1'b0; wait_clk(HOLD);
    sda = 1'b1; wait_clk(HOLD);
    scl = 1'b1; wait_clk(HOLD);
    chk(pos == 6'h21, "R7 no move while clock high", pos, 6'h21);
    scl = 1'b0; wait_clk(HOLD);
    chk(pos == 6'h22, "R7 move after clock falls", pos, 6'h22);
  endtask

  task automatic t_sat;
    write_pos(6'h3E);
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    chk(pos == 6'h3F, "R8 saturate at top", pos, 6'h3F);
    write_pos(6'h01);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    chk(pos == 6'h00, "R8 saturate at bottom", pos, 0);
  endtask

  task automatic t_stop;
    write_pos(6'h30);
    pulse(1'b1);
    chk(pos == 6'h31, "R9 step before stop", pos, 6'h31);
    scl = 1'b0; wait_clk(HOLD);
    sda = 1'b0; wait_clk(HOLD);
    scl = 1'b1; wait_clk(HOLD);
    sda = 1'b1; wait_clk(HOLD);
    chk(!stepping, "R9 stop ends session", stepping, 0);
    pulse(1'b0);
    chk(pos == 6'h31, "R9 stop pulse and later pulses ignored", pos, 6'h31);
    scl = 1'b1; sda = 1'b1; wait_clk(HOLD);
  endtask

  task automatic t_start;
    do_arm;
    chk(stepping, "R10 session reopened", stepping, 1);
    sda = 1'b0; wait_clk(HOLD);
    chk(!stepping, "R10 start ends session", stepping, 0);
    pulse(1'b1);
    chk(pos == 6'h31, "R10 no step after start", pos, 6'h31);
    scl = 1'b1; wait_clk(HOLD);
    sda = 1'b1; wait_clk(HOLD);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset;
    t_direct;
    t_xfer;
    t_prio;
    t_idle;
    t_steps;
    t_sat;
    t_stop;
    t_start;
    finish_run;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run;
  end
endmodule